// File: doc/BRIEF.md
# Cluster Tick Counter with Halt Freeze

This block is a free-running tick counter, shared by every core of a small multicore cluster. It advances by one on each clock. A core mask can tie it to the run state of up to four cores. Once every core selected by the mask reports halted, for example while a debugger holds the cluster stopped, the counter stops. It starts again as soon as any selected core runs. With this behaviour, timekeeping software sees no time pass while the cluster is stopped.

Software reaches the block through a small auxiliary register window. It places an operand in a write-data register and then writes an opcode to a command register. A result, if the command produces one, appears in a readback register. The opcodes read the counter low half, read the counter high half, load the core mask and return the core mask. A read-only build word reports the feature version and the number of cores. Reading the low half also captures the high half in a shadow register, so the two halves of one 64-bit value can be read one after the other.

Top module: `cluster_tick_counter`

## Requirements
- R1: Under synchronous active-high reset, the counter takes the value `RESET_VALUE` (default 0), and the core mask, the write-data register, the readback register and the high-half shadow all become 0.
- R2: While the core mask is all zeros, the counter advances by one on every clock edge, whatever `core_halted` carries.
- R3: Suppose the mask is non-zero and `core_halted` shows every selected core halted at a clock edge. The counter still advances at that edge and then holds its value from the following edge on.
- R4: The counter does not freeze while at least one core selected by the mask is not halted. Cores outside the mask have no effect.
- R5: Command opcode 0x47 loads the core mask from bits [3:0] of the write-data register and leaves the readback register unchanged.
- R6: Command opcode 0x48 places the core mask, zero-extended to 32 bits, into the readback register.
- R7: Command opcode 0x42 places bits [31:0] of the counter into the readback register and bits [63:32] into the shadow. Both values are taken as they stood before the counter update at the clock edge that accepts the command.
- R8: Command opcode 0x43 places the shadow into the readback register. The shadow reads 0 if no low-half read has happened since reset.
- R9: The opcode is bits [7:0] of the word written to the command register. Any opcode other than 0x42, 0x43, 0x47 or 0x48 sets the readback register to 0 and leaves the mask, the counter and the shadow unchanged.
- R10: The register window is decoded on `aux_addr`:
  - 0x600 is the command register. It is write-only and reads 0.
  - 0x601 is the write-data register. It can be written and read.
  - 0x602 is the readback register. It is read-only, and writes to it are ignored.
  - 0x0D6 is the build word. It reads bits [7:0] = 3 (version) and bits [15:8] = number of cores.
  - Every other address reads 0 and ignores writes.
- R11: Suppose the counter is frozen and the freeze condition clears at a clock edge. The counter still holds at that edge and advances again from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst | input | 1 | Synchronous reset, active high |
| aux_wr | input | 1 | Write strobe for the register window |
| aux_addr | input | 12 | Register window address, used for reads and writes |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data for `aux_addr`, combinational |
| core_halted | input | 4 | Per-core halt status, one bit per core, sampled on `clk` |
| tick_count | output | 64 | Current counter value |

## Verification
The bench builds the block with four cores, a 32-bit register word and `RESET_VALUE` set to 0x0000_0000_FFFF_FF80. With that reset value, the carry from the low half into the high half comes within a couple of hundred cycles. The bench can therefore check that a low-half read followed by a high-half read returns a consistent pair across that carry. Four cores give room to test a partial mask, where unselected halted cores must be ignored, against a full mask. Freeze entry and resume are checked against the one-cycle lag on both edges.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_CMD   = 12'h600;
    localparam logic [ADDR_W-1:0] ADDR_WDATA = 12'h601;
    localparam logic [ADDR_W-1:0] ADDR_RB    = 12'h602;
    localparam logic [ADDR_W-1:0] ADDR_BUILD = 12'h0D6;

    typedef enum logic [7:0] {
        OP_READ_LO  = 8'h42,
        OP_READ_HI  = 8'h43,
        OP_SET_MASK = 8'h47,
        OP_GET_MASK = 8'h48
    } op_e;

    typedef struct packed {
        logic fire;
        op_e  op;
    } cmd_t;

    function automatic logic [31:0] build_word(input int version, input int cores);
        return {16'h0000, 8'(cores), 8'(version)};
    endfunction

    function automatic logic op_known(input logic [7:0] code);
        return (code == OP_READ_LO) || (code == OP_READ_HI) ||
               (code == OP_SET_MASK) || (code == OP_GET_MASK);
    endfunction

endpackage

// File: rtl/ctc_halt_gate.sv
module ctc_halt_gate #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_mask,
    input  logic [NUM_CORES-1:0] new_mask,
    input  logic [NUM_CORES-1:0] core_halted,
    output logic [NUM_CORES-1:0] mask_o,
    output logic                 freeze_o
);

    logic [NUM_CORES-1:0] mask_q;
    logic                 freeze_q;
    logic                 all_sel_halted;

    assign all_sel_halted = (mask_q != '0) && ((core_halted & mask_q) == mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            freeze_q <= 1'b0;
        end else begin
            if (set_mask) mask_q <= new_mask;
            freeze_q <= all_sel_halted;
        end
    end

    assign mask_o   = mask_q;
    assign freeze_o = freeze_q;

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        set_mask |=> (mask_q == $past(new_mask))); // R5

    AST_EMPTY_NEVER_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !freeze_q); // R2

    AST_RUNNER_BLOCKS_FREEZE: assert property (@(posedge clk) disable iff (rst)
        ((~core_halted & mask_q) != '0) |=> !freeze_q); // R4

endmodule

// File: rtl/ctc_counter.sv
module ctc_counter #(
    parameter int               CNT_W       = 64,
    parameter logic [CNT_W-1:0] RESET_VALUE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)          count_q <= RESET_VALUE;
        else if (!freeze) count_q <= count_q + 1'b1;
    end

    assign count = count_q;

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(count_q)); // R3

    AST_RUN_STEPS_ONE: assert property (@(posedge clk) disable iff (rst)
        !freeze |=> (count_q == $past(count_q) + 1'b1)); // R2

endmodule

// File: rtl/ctc_cmd_port.sv
module ctc_cmd_port #(
    parameter int DATA_W    = 32,
    parameter int NUM_CORES = 4,
    parameter int VERSION   = 3,
    localparam int CNT_W    = 2 * DATA_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       aux_wr,
    input  logic [ctc_pkg::ADDR_W-1:0] aux_addr,
    input  logic [DATA_W-1:0]          aux_wdata,
    input  logic [CNT_W-1:0]           count,
    input  logic [NUM_CORES-1:0]       mask,
    output logic                       set_mask,
    output logic [NUM_CORES-1:0]       new_mask,
    output logic [DATA_W-1:0]          aux_rdata
);
    import ctc_pkg::*;

    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rb_q;
    logic [DATA_W-1:0] shadow_q;
    cmd_t              cmd;

    assign cmd.fire = aux_wr && (aux_addr == ADDR_CMD);
    assign cmd.op   = op_e'(aux_wdata[7:0]);

    assign set_mask = cmd.fire && (cmd.op == OP_SET_MASK);
    assign new_mask = wdata_q[NUM_CORES-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q  <= '0;
            rb_q     <= '0;
            shadow_q <= '0;
        end else begin
            if (aux_wr && (aux_addr == ADDR_WDATA)) wdata_q <= aux_wdata;
            if (cmd.fire) begin
                case (cmd.op)
                    OP_READ_LO: begin
                        rb_q     <= count[DATA_W-1:0];
                        shadow_q <= count[CNT_W-1:DATA_W];
                    end
                    OP_READ_HI:  rb_q <= shadow_q;
                    OP_SET_MASK: rb_q <= rb_q;
                    OP_GET_MASK: rb_q <= DATA_W'(mask);
                    default:     rb_q <= '0;
                endcase
            end
        end
    end

    always_comb begin
        case (aux_addr)
            ADDR_WDATA: aux_rdata = wdata_q;
            ADDR_RB:    aux_rdata = rb_q;
            ADDR_BUILD: aux_rdata = DATA_W'(build_word(VERSION, NUM_CORES));
            default:    aux_rdata = '0;
        endcase
    end

    AST_UNKNOWN_CLEARS_RB: assert property (@(posedge clk) disable iff (rst)
        (cmd.fire && !op_known(aux_wdata[7:0])) |=> (rb_q == '0)); // R9

    AST_LO_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
        (cmd.fire && (aux_wdata[7:0] == 8'h42)) |=> (rb_q == $past(count[DATA_W-1:0]))); // R7

    AST_GET_MASK_RB: assert property (@(posedge clk) disable iff (rst)
        (cmd.fire && (aux_wdata[7:0] == 8'h48)) |=> (rb_q == DATA_W'($past(mask)))); // R6

    AST_RB_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (aux_wr && (aux_addr == ADDR_RB)) |=> $stable(rb_q)); // R10

endmodule

// File: rtl/cluster_tick_counter.sv
module cluster_tick_counter #(
    parameter int                   DATA_W      = 32,
    parameter int                   NUM_CORES   = 4,
    parameter int                   VERSION     = 3,
    parameter logic [2*DATA_W-1:0]  RESET_VALUE = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       aux_wr,
    input  logic [ctc_pkg::ADDR_W-1:0] aux_addr,
    input  logic [DATA_W-1:0]          aux_wdata,
    output logic [DATA_W-1:0]          aux_rdata,
    input  logic [NUM_CORES-1:0]       core_halted,
    output logic [2*DATA_W-1:0]        tick_count
);
    localparam int CNT_W = 2 * DATA_W;

    logic                 set_mask;
    logic [NUM_CORES-1:0] new_mask;
    logic [NUM_CORES-1:0] mask;
    logic                 freeze;

    ctc_cmd_port #(
        .DATA_W    (DATA_W),
        .NUM_CORES (NUM_CORES),
        .VERSION   (VERSION)
    ) u_port (
        .clk       (clk),
        .rst       (rst),
        .aux_wr    (aux_wr),
        .aux_addr  (aux_addr),
        .aux_wdata (aux_wdata),
        .count     (tick_count),
        .mask      (mask),
        .set_mask  (set_mask),
        .new_mask  (new_mask),
        .aux_rdata (aux_rdata)
    );

    ctc_halt_gate #(
        .NUM_CORES (NUM_CORES)
    ) u_gate (
        .clk         (clk),
        .rst         (rst),
        .set_mask    (set_mask),
        .new_mask    (new_mask),
        .core_halted (core_halted),
        .mask_o      (mask),
        .freeze_o    (freeze)
    );

    ctc_counter #(
        .CNT_W       (CNT_W),
        .RESET_VALUE (RESET_VALUE)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .freeze (freeze),
        .count  (tick_count)
    );

    AST_ALL_HALTED_FREEZES: assert property (@(posedge clk) disable iff (rst)
        ((mask != '0) && ((core_halted & mask) == mask)) |=> ##1 $stable(tick_count)); // R3

    AST_RESUME_LAG: assert property (@(posedge clk) disable iff (rst)
        $fell(freeze) |-> $stable(tick_count)); // R11

endmodule

// File: tb/cluster_tick_counter_test.sv
module cluster_tick_counter_test;

    localparam logic [63:0] RV = 64'h0000_0000_FFFF_FF80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        aux_wr = 1'b0;
    logic [11:0] aux_addr = 12'h602;
    logic [31:0] aux_wdata = '0;
    logic [31:0] aux_rdata;
    logic [3:0]  core_halted = '0;
    logic [63:0] tick_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cluster_tick_counter #(.RESET_VALUE(RV)) uut (
        .clk(clk), .rst(rst), .aux_wr(aux_wr), .aux_addr(aux_addr),
        .aux_wdata(aux_wdata), .aux_rdata(aux_rdata),
        .core_halted(core_halted), .tick_count(tick_count)
    );

    always #10 clk = ~clk;

    // behavioural reference
    logic [63:0] m_cnt;
    logic [3:0]  m_mask;
    bit          m_frz;
    logic [31:0] m_rb, m_sh, m_wd;

    always @(posedge clk) begin
        logic [63:0] n_cnt;
        logic [3:0]  n_mask;
        logic [31:0] n_rb, n_sh, n_wd;
        bit          n_frz;
        if (rst) begin
            m_cnt = RV; m_mask = 0; m_frz = 0; m_rb = 0; m_sh = 0; m_wd = 0;
        end else begin
            n_cnt = m_frz ? m_cnt : m_cnt + 64'd1;
            n_frz = (m_mask != 0) && ((core_halted & m_mask) == m_mask);
            n_mask = m_mask; n_rb = m_rb; n_sh = m_sh; n_wd = m_wd;
            if (aux_wr && aux_addr == 12'h601) n_wd = aux_wdata;
            if (aux_wr && aux_addr == 12'h600) begin
                if (aux_wdata[7:0] == 8'h42) begin n_rb = m_cnt[31:0]; n_sh = m_cnt[63:32]; end
                else if (aux_wdata[7:0] == 8'h43) n_rb = m_sh;
                else if (aux_wdata[7:0] == 8'h47) n_mask = m_wd[3:0];
                else if (aux_wdata[7:0] == 8'h48) n_rb = {28'd0, m_mask};
                else n_rb = 0;
            end
            m_cnt = n_cnt; m_frz = n_frz; m_mask = n_mask; m_rb = n_rb; m_sh = n_sh; m_wd = n_wd;
        end
    end

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h601: return m_wd;
            12'h602: return m_rb;
            12'h0D6: return 32'h0000_0403;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(tick_count == m_cnt, (m_mask == 0) ? "R2 count" : "R3/R4/R11 count", tick_count, m_cnt);
            chk(aux_rdata == m_read(aux_addr), "R10 read data", aux_rdata, m_read(aux_addr));
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        tick(); aux_wr = 1'b1; aux_addr = a; aux_wdata = d;
        tick(); aux_wr = 1'b0; aux_addr = 12'h602; aux_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        aux_addr = a; #1; v = aux_rdata; aux_addr = 12'h602;
    endtask

    initial begin
        logic [31:0] v, lo, hi;
        logic [63:0] c0;
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk(tick_count == RV, "R1 count reset", tick_count, RV);
        rd(12'h602, v); chk(v == 0, "R1 readback reset", v, 0);
        wr(12'h600, 32'h48); rd(12'h602, v); chk(v == 0, "R1 mask reset", v, 0);

        // R10 address map
        rd(12'h0D6, v); chk(v == 32'h0000_0403, "R10 build word", v, 32'h403);
        rd(12'h600, v); chk(v == 0, "R10 cmd reads zero", v, 0);
        rd(12'h123, v); chk(v == 0, "R10 unmapped reads zero", v, 0);
        wr(12'h601, 32'hA5A5_0005); rd(12'h601, v); chk(v == 32'hA5A5_0005, "R10 wdata rw", v, 32'hA5A5_0005);
        wr(12'h602, 32'hDEAD_BEEF); rd(12'h602, v); chk(v == 0, "R10 readback read-only", v, 0);

        // R2 empty mask ignores halts
        core_halted = 4'hF; @(negedge clk); c0 = tick_count;
        repeat (4) tick(); @(negedge clk);
        chk(tick_count == c0 + 4, "R2 empty mask keeps counting", tick_count, c0 + 4);
        core_halted = 4'h0;

        // R5/R6 load and read mask
        wr(12'h600, 32'hFFFF_FF47);
        wr(12'h600, 32'h48); rd(12'h602, v); chk(v == 32'h5, "R6 mask readback", v, 5);
        chk(v == 32'h5, "R5 mask loaded from wdata bits 3:0", v, 5);

        // R9 unknown opcode
        wr(12'h600, 32'h55); rd(12'h602, v); chk(v == 0, "R9 unknown clears readback", v, 0);
        wr(12'h600, 32'h48); rd(12'h602, v); chk(v == 32'h5, "R9 mask untouched", v, 5);

        // R4 partial halt keeps counting, unselected cores ignored
        tick(); core_halted = 4'b1011; @(negedge clk); c0 = tick_count;
        repeat (3) tick(); @(negedge clk);
        chk(tick_count == c0 + 3, "R4 partial halt counts", tick_count, c0 + 3);

        // R3 freeze with one-cycle lag
        tick(); core_halted = 4'b0101; @(negedge clk); c0 = tick_count;
        @(negedge clk); chk(tick_count == c0 + 1, "R3 advances on sampling edge", tick_count, c0 + 1);
        repeat (3) @(negedge clk);
        chk(tick_count == c0 + 1, "R3 held while frozen", tick_count, c0 + 1);

        // R11 resume with one-cycle lag
        tick(); core_halted = 4'b0100; @(negedge clk); c0 = tick_count;
        @(negedge clk); chk(tick_count == c0, "R11 holds on resume edge", tick_count, c0);
        @(negedge clk); chk(tick_count == c0 + 1, "R11 advances after", tick_count, c0 + 1);
        core_halted = 4'h0;

        // R8 shadow before any low read is zero... already read none since reset
        wr(12'h600, 32'h43); rd(12'h602, v); chk(v == 0, "R8 shadow zero before low read", v, 0);

        // R7/R8 consistent pair across the low-half carry
        while (tick_count[31:0] < 32'hFFFF_FFFE && tick_count[63:32] == 0) tick();
        wr(12'h600, 32'h42); rd(12'h602, lo);
        repeat (4) tick();
        wr(12'h600, 32'h43); rd(12'h602, hi);
        chk({hi, lo} == 64'h0000_0000_FFFF_FFFE || {hi, lo} == 64'h0000_0000_FFFF_FFFF,
            "R7 low snapshot before carry", {hi, lo}, 64'hFFFF_FFFE);
        chk(hi == 0, "R8 high from shadow", hi, 0);
        wr(12'h600, 32'h43); rd(12'h602, v); chk(tick_count[63:32] == 1 && v == 0, "R8 shadow stable after carry", v, 0);
        wr(12'h600, 32'h42); wr(12'h600, 32'h43); rd(12'h602, v); chk(v == 1, "R8 high after carry", v, 1);

        repeat (3) tick();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule